// File: doc/BRIEF.md
# Single-Source Edge Interrupt Unit

This block watches one active-low interrupt pin for a core that runs in instruction cycles. The pin is brought into the clock domain through a small synchronizer. A request counts only when the pin has stayed low across at least two instruction-cycle boundaries in a row. A qualified request is kept only if the interrupt-enable flag is set at that moment. A request that arrives while the flag is clear is dropped and is not kept for later.

A kept request waits until the core reaches an instruction boundary where it is safe to break in. That boundary must not fall inside a transfer of control that is still running, nor in the middle of a run of consecutive pointer-load instructions. At that boundary the block raises a single-cycle service pulse. The core reacts to it by pushing its current program counter onto the return stack and fetching from the fixed vector address on `vec_addr`. Taking the interrupt clears the enable flag, so a second request cannot nest until software sets the flag again.

Every pin of the block is a plain control or status pin. The block has no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `irq_edge_unit`

## Requirements
- R1: After reset `svc_take` is 0, `armed` is 0, and `vec_addr` equals the vector parameter (default 11-bit 0x0FF).
- R2: A request is qualified only when the synchronized pin is sampled low at MIN_LOW_CYC (default 2) consecutive `cyc_stb` cycles. A low period that spans only one strobe never leads to `svc_take`.
- R3: The low-time count returns to zero on any clock in which the synchronized pin is high, even for one clock. Two short low periods split by a high gap therefore do not add up.
- R4: One unbroken low period qualifies at most one request, however long it lasts. This holds even if the enable flag is set again while the pin is still low.
- R5: A cycle with `en_load` = 1 loads `armed` from `en_bit`. Here `en_bit` is the core's enable-register bit 1. The new value of `armed` appears on the next clock.
- R6: A request that qualifies while `armed` is 0 is discarded. Setting `armed` afterwards does not produce `svc_take` for it.
- R7: `svc_take` is never raised after a strobe at which `xfer_busy` = 1. A pending request is serviced at the first strobe with `xfer_busy` = 0 and `ptr_run` = 0.
- R8: `svc_take` is never raised after a strobe at which `ptr_run` = 1, so a run of pointer loads always finishes first.
- R9: `svc_take` is high for exactly one clock, and in that clock `vec_addr` = 0x0FF and `armed` = 0.
- R10: `svc_take` rises only in the clock right after a clock with `cyc_stb` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| irq_pin_n | input | 1 | Asynchronous interrupt pin, active low |
| cyc_stb | input | 1 | One-clock strobe at each instruction-cycle boundary |
| en_load | input | 1 | Write strobe for the enable flag |
| en_bit | input | 1 | Value written to the enable flag (enable register bit 1) |
| xfer_busy | input | 1 | Current instruction is a transfer of control that has not finished |
| ptr_run | input | 1 | Current instruction is part of a run of consecutive pointer loads |
| svc_take | output | 1 | Push-PC-and-vector request, one clock wide |
| vec_addr | output | 11 | Fixed service vector address |
| armed | output | 1 | Current value of the enable flag |

## Verification
Low pulses of several shapes are applied to the pin. A pulse that covers one strobe separates a width check that works from one that fires on any low. A low–high–low glitch shows whether the count restarts when the pin goes high. A long low hold with re-arming part-way through catches a detector that fires more than once per low period. Further qualified pulses are sent while the enable flag is clear, while a transfer is busy, and during a pointer-load run. These show that a request is dropped in the first case and held back in the other two, and that service comes out at the first clean boundary.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int DEF_PC_W = 11;
  localparam logic [DEF_PC_W-1:0] DEF_VEC = 11'h0FF;
  localparam int DEF_SYNC = 2;
  localparam int DEF_MIN_LOW = 2;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] sh;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sh[i] <= 1'b1;
          else        sh[i] <= din;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sh[i] <= 1'b1;
          else        sh[i] <= sh[i-1];
      end
    end
  endgenerate

  assign dout = sh[STAGES-1];
endmodule

// File: rtl/irq_width_qual.sv
module irq_width_qual #(
  parameter int MIN_LOW = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_s,
  input  logic stb,
  output logic det
);
  localparam int CW = $clog2(MIN_LOW + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      det <= 1'b0;
    end else begin
      det <= 1'b0;
      if (pin_s) begin
        cnt <= '0;
      end else if (stb && cnt != CW'(MIN_LOW)) begin
        cnt <= cnt + 1'b1;
        if (cnt == CW'(MIN_LOW - 1)) det <= 1'b1;
      end
    end
  end

  p_cnt_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pin_s |=> (cnt == '0));
  p_det_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
    det |=> !det);
  p_det_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    det |-> $past(!pin_s && stb));
endmodule

// File: rtl/irq_service.sv
module irq_service (
  input  logic clk,
  input  logic rst_n,
  input  logic det,
  input  logic stb,
  input  logic en_load,
  input  logic en_bit,
  input  logic xfer_busy,
  input  logic ptr_run,
  output logic take,
  output logic armed
);
  logic pend;
  logic safe_pt;

  assign safe_pt = stb && !xfer_busy && !ptr_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      pend  <= 1'b0;
      take  <= 1'b0;
    end else begin
      take <= 1'b0;
      if (en_load) armed <= en_bit;
      if (det && armed) pend <= 1'b1;
      if (!armed) pend <= 1'b0;
      if (pend && armed && safe_pt) begin
        take  <= 1'b1;
        pend  <= 1'b0;
        armed <= 1'b0;
      end
    end
  end

  p_take_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !take);
  p_take_disarms_r9: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> !armed);
  p_take_after_stb_r10: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> $past(stb));
  p_no_take_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> $past(!xfer_busy));
  p_no_take_ptr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> $past(!ptr_run));
  p_pend_needs_arm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !armed && !en_load) |=> !pend);
endmodule

// File: rtl/irq_edge_unit.sv
module irq_edge_unit
  import irq_pkg::*;
#(
  parameter int                PC_W    = DEF_PC_W,
  parameter logic [PC_W-1:0]   VEC     = DEF_VEC,
  parameter int                SYNC    = DEF_SYNC,
  parameter int                MIN_LOW = DEF_MIN_LOW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            irq_pin_n,
  input  logic            cyc_stb,
  input  logic            en_load,
  input  logic            en_bit,
  input  logic            xfer_busy,
  input  logic            ptr_run,
  output logic            svc_take,
  output logic [PC_W-1:0] vec_addr,
  output logic            armed
);
  logic pin_s;
  logic det;

  irq_sync #(.STAGES(SYNC)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(irq_pin_n), .dout(pin_s)
  );

  irq_width_qual #(.MIN_LOW(MIN_LOW)) u_qual (
    .clk(clk), .rst_n(rst_n), .pin_s(pin_s), .stb(cyc_stb), .det(det)
  );

  irq_service u_svc (
    .clk(clk), .rst_n(rst_n), .det(det), .stb(cyc_stb),
    .en_load(en_load), .en_bit(en_bit), .xfer_busy(xfer_busy),
    .ptr_run(ptr_run), .take(svc_take), .armed(armed)
  );

  assign vec_addr = VEC;
endmodule

// File: tb/sim_irq_edge_unit.sv
module sim_irq_edge_unit;
  logic clk = 0, rst_n = 0;
  logic irq_pin_n = 1, cyc_stb = 0, en_load = 0, en_bit = 0;
  logic xfer_busy = 0, ptr_run = 0;
  logic svc_take, armed;
  logic [10:0] vec_addr;

  int checks = 0, fails = 0, scen = 0;
  int exp_q[$];
  bit done = 0;

  always #4 clk = ~clk;

  irq_edge_unit u0 (
    .clk(clk), .rst_n(rst_n), .irq_pin_n(irq_pin_n), .cyc_stb(cyc_stb),
    .en_load(en_load), .en_bit(en_bit), .xfer_busy(xfer_busy),
    .ptr_run(ptr_run), .svc_take(svc_take), .vec_addr(vec_addr), .armed(armed)
  );

  // strobe every 4 clocks
  initial begin
    @(negedge clk);
    forever begin
      repeat (3) @(negedge clk);
      cyc_stb = 1;
      @(negedge clk);
      cyc_stb = 0;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: pop expected services as they appear
  always @(negedge clk) begin
    if (rst_n && svc_take) begin
      if (exp_q.size() == 0) begin
        chk("R2/R4/R6/R7/R8 unexpected svc_take", 1, 0);
      end else begin
        int s;
        s = exp_q.pop_front();
        chk("R7 service in scenario", scen, s);
        chk("R9 vec_addr at service", vec_addr, 11'h0FF);
        chk("R9 armed clear at service", armed, 0);
      end
    end
  end

  task automatic low_for(input int n);
    irq_pin_n = 0;
    repeat (n) @(negedge clk);
    irq_pin_n = 1;
  endtask

  task automatic set_en(input bit v);
    en_bit = v; en_load = 1;
    @(negedge clk);
    en_load = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic end_scen(input string req);
    chk(req, exp_q.size(), 0);
  endtask

  initial begin
    idle(3);
    chk("R1 svc_take reset", svc_take, 0);
    chk("R1 armed reset", armed, 0);
    chk("R1 vec_addr", vec_addr, 11'h0FF);
    rst_n = 1;
    idle(2);

    // R5: arming
    scen = 1; set_en(1);
    chk("R5 armed after load", armed, 1);

    // R2: short pulse, one strobe only
    scen = 2; low_for(4); idle(30);
    end_scen("R2 short pulse");

    // R3: glitch splits count
    scen = 3; low_for(4); idle(4); low_for(4); idle(30);
    end_scen("R3 split low");

    // R4/R9: long hold, rearm while low
    scen = 4; exp_q.push_back(4);
    irq_pin_n = 0; idle(40);
    chk("R9 armed cleared after take", armed, 0);
    set_en(1); idle(30);
    irq_pin_n = 1; idle(10);
    end_scen("R4 single service per low period");
    chk("R5 armed kept", armed, 1);

    // R6: request while disarmed is dropped
    scen = 6; set_en(0);
    chk("R5 armed cleared by load", armed, 0);
    low_for(16); idle(10); set_en(1); idle(40);
    end_scen("R6 dropped request");

    // R7: transfer in progress defers
    scen = 7; xfer_busy = 1; low_for(16); idle(30);
    exp_q.push_back(7); xfer_busy = 0; idle(20);
    end_scen("R7 deferred then served");

    // R8: pointer-load run defers
    scen = 8; set_en(1); ptr_run = 1; low_for(16); idle(30);
    exp_q.push_back(8); ptr_run = 0; idle(20);
    end_scen("R8 deferred then served");

    // R10: plain service again with both flags clear
    scen = 10; set_en(1); exp_q.push_back(10); low_for(16); idle(20);
    end_scen("R10 service on strobe");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule